// File: doc/BRIEF.md
# Video RAM Block Copy Engine

This engine copies data from anywhere in the 16-bit address space into the 8 KiB video RAM window at 0x8000–0x9FFF, always in units of 16 bytes. Software sets it up through five byte-wide registers. Indices 0 and 1 hold the source (high byte, low byte), indices 2 and 3 hold the destination (high byte, low byte), and index 4 holds the length and the mode. A write to index 4 launches the work. While bytes are moving, the engine holds the processor stalled and drives a byte-wide master port, one read and one write per byte.

There are two modes. In the immediate mode the whole length is moved in one run. In the blanking-paced mode the engine waits and moves one 16-byte chunk for each rising edge of a blanking pulse input. At the end of every run the engine writes its current source and destination back into the four address registers, so a follow-on transfer can continue where the last one stopped. Index 4 reports progress or completion.

Top module: `vdma_engine`

## Requirements
- R1: The source start address is {index0, index1} with bits [3:0] forced to zero. The first master read goes to that address, and each following byte reads the next address, wrapping at 0xFFFF.
- R2: A write to index 4 is ignored when the aligned source lies in 0x8000–0x9FFF. No read or write is issued, the stall stays low and index 4 keeps its old value.
- R3: Every master write goes to 0x8000 | (offset & 0x1FFF). The offset starts at {index2, index3} & 0x1FF0, rises by one per byte and wraps inside the window.
- R4: Bits [6:0] of the value n written to index 4 give the length: (n+1)×16 bytes in immediate mode and (n+1) chunks of 16 bytes in blanking-paced mode. Bit 7 = 0 selects immediate mode and bit 7 = 1 selects blanking-paced mode.
- R5: Each byte takes two cycles: a read cycle, then a write cycle that carries the data the memory returned one cycle after the read. For a run of N bytes, cpu_stall is high for exactly 2N+1 cycles, starting in the cycle after the launching clock edge.
- R6: When a run ends, indices 0..3 read back the next source address (high, low) and the next destination, with index 2 returned as 0x80 | offset[12:8].
- R7: After an immediate run, index 4 reads 0x80 | n.
- R8: Blanking-paced mode moves nothing until a rising edge of hblank arrives while the engine is idle. Each such edge moves exactly 16 bytes. Keeping hblank high, or toggling it while a chunk is moving, starts no further chunk.
- R9: In blanking-paced mode, index 4 reads {0, count}: n after arming, then one less after each chunk. After the last chunk it reads 0xFF and the mode is disarmed, so later edges move nothing.
- R10: A write to index 4 with bit 7 = 0 while blanking-paced mode is armed cancels that mode without moving any data. Index 4 then reads 0x80 | n.
- R11: After reset, indices 0..3 read 0x00, index 4 reads 0xFF, cpu_stall is low and no master access is issued.
- R12: Register writes presented while cpu_stall is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_sel | input | 3 | Register index 0..4 |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_sel (combinational) |
| hblank | input | 1 | Blanking pulse; its rising edge paces chunks |
| cpu_stall | output | 1 | Holds the processor while a run is in progress |
| mem_rd_en | output | 1 | Master read request |
| mem_wr_en | output | 1 | Master write request |
| mem_addr | output | 16 | Master address |
| mem_wdata | output | 8 | Master write data |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd_en |

## Verification
A launching write or hblank edge is taken at a clock edge. The first read appears in the next cycle, and each write follows its read by exactly one cycle. The stall therefore lasts 2N+1 cycles, and the written-back registers are readable as soon as the stall falls. The bench samples every master access and the stall on falling edges. It counts stall cycles against 2N+1, checks each access against its own running source and destination pointers, and reads registers back only after the stall has fallen. Any access that appears while the bench expects no traffic is reported against the requirement under test.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  localparam int VD_LEN_W     = 7;
  localparam int VD_CHUNK_LOG = 4;
  localparam int VD_CNT_W     = VD_LEN_W + VD_CHUNK_LOG + 1;
  localparam int VD_WIN_W     = 13;
  localparam logic [2:0] VD_WIN_TOP = 3'b100;
  localparam int VD_NREGS     = 5;

  function automatic logic [15:0] fn_src_align(input logic [7:0] hi, input logic [7:0] lo);
    return {hi, lo[7:VD_CHUNK_LOG], {VD_CHUNK_LOG{1'b0}}};
  endfunction

  function automatic logic fn_src_in_window(input logic [15:0] a);
    return a[15:VD_WIN_W] == VD_WIN_TOP;
  endfunction

  function automatic logic [VD_WIN_W-1:0] fn_dst_offset(input logic [7:0] hi, input logic [7:0] lo);
    logic [15:0] raw;
    raw = {hi, lo};
    return {raw[VD_WIN_W-1:VD_CHUNK_LOG], {VD_CHUNK_LOG{1'b0}}};
  endfunction

  function automatic logic [VD_CNT_W-1:0] fn_len_bytes(input logic [VD_LEN_W-1:0] n);
    logic [VD_CNT_W-1:0] units;
    units = VD_CNT_W'(n) + 1'b1;
    return units << VD_CHUNK_LOG;
  endfunction
endpackage

// File: rtl/vdma_regs.sv
module vdma_regs
  import vdma_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_we,
  input  logic [2:0]          cpu_sel,
  input  logic [7:0]          cpu_wdata,
  input  logic                wb_en,
  input  logic [15:0]         wb_src,
  input  logic [VD_WIN_W-1:0] wb_dst,
  input  logic                len_we,
  input  logic [7:0]          len_val,
  output logic [7:0]          src_hi,
  output logic [7:0]          src_lo,
  output logic [7:0]          dst_hi,
  output logic [7:0]          dst_lo,
  output logic [7:0]          len_q,
  output logic [7:0]          rdata
);
  logic [7:0] areg [4];
  logic [7:0] wb_byte [4];

  always_comb begin
    wb_byte[0] = wb_src[15:8];
    wb_byte[1] = wb_src[7:0];
    wb_byte[2] = 8'({VD_WIN_TOP, wb_dst[VD_WIN_W-1:8]});
    wb_byte[3] = wb_dst[7:0];
  end

  for (genvar i = 0; i < 4; i++) begin : g_addr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  areg[i] <= 8'h00;
      else if (wb_en)                              areg[i] <= wb_byte[i];
      else if (cpu_we && cpu_sel == 3'(i))         areg[i] <= cpu_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= 8'hFF;
    else if (len_we) len_q <= len_val;
  end

  assign src_hi = areg[0];
  assign src_lo = areg[1];
  assign dst_hi = areg[2];
  assign dst_lo = areg[3];

  always_comb begin
    if (cpu_sel < 3'd4)                      rdata = areg[cpu_sel[1:0]];
    else if (cpu_sel == 3'(VD_NREGS - 1))    rdata = len_q;
    else                                     rdata = 8'hFF;
  end

  p_writeback_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> (src_hi == $past(wb_src[15:8]) && dst_lo == $past(wb_dst[7:0])));
endmodule

// File: rtl/vdma_mover.sv
module vdma_mover
  import vdma_pkg::*;
#(
  parameter int CNT_W = VD_CNT_W
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [15:0]         ld_src,
  input  logic [VD_WIN_W-1:0] ld_dst,
  input  logic                go,
  input  logic [CNT_W-1:0]    go_bytes,
  input  logic [7:0]          mem_rdata,
  output logic                busy,
  output logic                done,
  output logic [15:0]         cur_src,
  output logic [VD_WIN_W-1:0] cur_dst,
  output logic                mem_rd_en,
  output logic                mem_wr_en,
  output logic [15:0]         mem_addr,
  output logic [7:0]          mem_wdata
);
  logic             phase;
  logic [CNT_W-1:0] left;
  logic             last_byte;

  assign last_byte = busy && phase && (left == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; phase <= 1'b0; left <= '0;
      cur_src <= '0; cur_dst <= '0;
    end else begin
      done <= last_byte;
      if (load) begin
        cur_src <= ld_src;
        cur_dst <= ld_dst;
      end
      if (go) begin
        busy  <= 1'b1;
        left  <= go_bytes;
        phase <= 1'b0;
      end else if (busy) begin
        phase <= ~phase;
        if (phase) begin
          cur_src <= cur_src + 16'd1;
          cur_dst <= cur_dst + 1'b1;
          left    <= left - 1'b1;
          if (last_byte) busy <= 1'b0;
        end
      end
    end
  end

  assign mem_rd_en = busy && !phase;
  assign mem_wr_en = busy && phase;
  assign mem_addr  = phase ? {VD_WIN_TOP, cur_dst} : cur_src;
  assign mem_wdata = mem_rdata;

  p_wr_follows_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> mem_wr_en);
  p_rd_before_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(mem_rd_en));
  p_dst_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> mem_addr[15:VD_WIN_W] == VD_WIN_TOP);
  p_done_after_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(mem_wr_en) && !busy));
  p_go_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (go_bytes != '0 && !busy));
endmodule

// File: rtl/vdma_engine.sv
module vdma_engine
  import vdma_pkg::*;
#(
  parameter int LEN_W     = VD_LEN_W,
  parameter int CHUNK_LOG = VD_CHUNK_LOG
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_sel,
  input  logic        reg_wr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        hblank,
  output logic        cpu_stall,
  output logic        mem_rd_en,
  output logic        mem_wr_en,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata
);
  localparam int CNT_W = LEN_W + CHUNK_LOG + 1;

  logic [7:0] src_hi, src_lo, dst_hi, dst_lo, len_q;
  logic mover_busy, mover_done;
  logic [15:0] cur_src;
  logic [VD_WIN_W-1:0] cur_dst;
  logic armed, run_is_gen, hb_prev;

  // named events for the checks
  logic accept, cfg_wr, src_bad, start_wr, mode_blank;
  logic gen_go, arm_go, cancel, hb_rise, chunk_go, go;
  logic [15:0] src_al;
  logic [CNT_W-1:0] go_bytes;
  logic len_we;
  logic [7:0] len_val;
  logic [LEN_W-1:0] n_field;

  assign cpu_stall  = mover_busy | mover_done;
  assign accept     = reg_wr & ~cpu_stall;
  assign cfg_wr     = accept && reg_sel == 3'(VD_NREGS - 1);
  assign src_al     = fn_src_align(src_hi, src_lo);
  assign src_bad    = fn_src_in_window(src_al);
  assign start_wr   = cfg_wr & ~src_bad;
  assign mode_blank = reg_wdata[7];
  assign n_field    = reg_wdata[LEN_W-1:0];
  assign gen_go     = start_wr & ~mode_blank & ~armed;
  assign cancel     = start_wr & ~mode_blank & armed;
  assign arm_go     = start_wr & mode_blank;
  assign hb_rise    = hblank & ~hb_prev;
  assign chunk_go   = armed & hb_rise & ~cpu_stall & ~accept;
  assign go         = gen_go | chunk_go;
  assign go_bytes   = gen_go ? fn_len_bytes(n_field) : CNT_W'(1 << CHUNK_LOG);

  always_comb begin
    len_we  = 1'b1;
    len_val = len_q;
    if (gen_go || arm_go)          len_val = {1'b0, n_field};
    else if (cancel)               len_val = {1'b1, n_field};
    else if (mover_done && run_is_gen) len_val = {1'b1, len_q[6:0]};
    else if (mover_done)           len_val = len_q - 8'd1;
    else                           len_we  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; run_is_gen <= 1'b0; hb_prev <= 1'b0;
    end else begin
      hb_prev <= hblank;
      if (gen_go)        run_is_gen <= 1'b1;
      else if (chunk_go) run_is_gen <= 1'b0;
      if (arm_go)        armed <= 1'b1;
      else if (cancel)   armed <= 1'b0;
      else if (mover_done && !run_is_gen && len_q == 8'h00) armed <= 1'b0;
    end
  end

  vdma_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .cpu_we(accept), .cpu_sel(reg_sel), .cpu_wdata(reg_wdata),
    .wb_en(mover_done), .wb_src(cur_src), .wb_dst(cur_dst),
    .len_we(len_we), .len_val(len_val),
    .src_hi(src_hi), .src_lo(src_lo), .dst_hi(dst_hi), .dst_lo(dst_lo),
    .len_q(len_q), .rdata(reg_rdata)
  );

  vdma_mover #(.CNT_W(CNT_W)) u_mover (
    .clk(clk), .rst_n(rst_n),
    .load(gen_go | arm_go), .ld_src(src_al),
    .ld_dst(fn_dst_offset(dst_hi, dst_lo)),
    .go(go), .go_bytes(go_bytes), .mem_rdata(mem_rdata),
    .busy(mover_busy), .done(mover_done),
    .cur_src(cur_src), .cur_dst(cur_dst),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  p_reject_vram_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && src_bad) |=> (!mover_busy && $stable(len_q)));
  p_stall_covers_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || mem_wr_en) |-> cpu_stall);
  p_armed_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> !len_q[7]);
  p_gen_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mover_done && run_is_gen) |=> len_q[7]);
  p_cancel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> (!armed && !mover_busy));
  p_no_write_stalled_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && cpu_stall && !mover_done) |=> $stable(src_hi));
endmodule

// File: tb/tb_vdma_engine.sv
module tb_vdma_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] reg_sel = 3'd0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic hblank = 1'b0;
  logic cpu_stall, mem_rd_en, mem_wr_en;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = 8'h00;

  int checks = 0;
  int errors = 0;
  int stall_cycles = 0;
  int exp_left = 0;
  logic [15:0] exp_src = '0;
  logic [12:0] exp_dst = '0;
  string cur_req = "R11";
  bit done_flag = 0;

  always #4 clk = ~clk;

  vdma_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hblank(hblank),
    .cpu_stall(cpu_stall), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] src_fn(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h3C;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory model: read data valid the cycle after the read
  always @(posedge clk) if (mem_rd_en) mem_rdata <= src_fn(mem_addr);

  // bus monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (cpu_stall) stall_cycles++;
      if ((mem_rd_en || mem_wr_en) && exp_left == 0) begin
        chk(cur_req, {15'd0, mem_rd_en, mem_addr}, 32'h0);
      end else if (mem_rd_en) begin
        chk("R1", {16'd0, mem_addr}, {16'd0, exp_src});
      end else if (mem_wr_en) begin
        chk("R3", {16'd0, mem_addr}, {16'd0, 3'b100, exp_dst});
        chk("R5", {24'd0, mem_wdata}, {24'd0, src_fn(exp_src)});
        exp_src  = exp_src + 16'd1;
        exp_dst  = exp_dst + 13'd1;
        exp_left = exp_left - 1;
      end
    end
  end

  task automatic final_report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      final_report();
    end
  end

  task automatic wr_reg(input logic [2:0] s, input logic [7:0] v);
    @(negedge clk);
    reg_sel = s; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] s, input logic [7:0] exp);
    reg_sel = s;
    #1;
    chk(req, {24'd0, reg_rdata}, {24'd0, exp});
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 20000 && cpu_stall; g++) @(negedge clk);
  endtask

  task automatic check_regs(input string req, input logic [15:0] s, input logic [12:0] d);
    rd_chk(req, 3'd0, s[15:8]);
    rd_chk(req, 3'd1, s[7:0]);
    rd_chk(req, 3'd2, {3'b100, d[12:8]});
    rd_chk(req, 3'd3, d[7:0]);
  endtask

  task automatic setup_addr(input logic [15:0] s, input logic [15:0] d);
    wr_reg(3'd0, s[15:8]); wr_reg(3'd1, s[7:0]);
    wr_reg(3'd2, d[15:8]); wr_reg(3'd3, d[7:0]);
  endtask

  task automatic run_general(input logic [15:0] s, input logic [15:0] d,
                             input logic [6:0] n, input bit poke);
    int nb;
    logic [15:0] s_end;
    logic [12:0] d_end;
    setup_addr(s, d);
    nb = (int'(n) + 1) * 16;
    exp_src = {s[15:4], 4'h0};
    exp_dst = {d[12:4], 4'h0};
    exp_left = nb;
    s_end = exp_src + 16'(nb);
    d_end = exp_dst + 13'(nb);
    cur_req = "R4";
    stall_cycles = 0;
    wr_reg(3'd4, {1'b0, n});
    if (poke) begin
      repeat (3) @(negedge clk);
      wr_reg(3'd0, 8'h55);
      wr_reg(3'd4, 8'h83);
    end
    wait_idle();
    chk("R5", stall_cycles, 2 * nb + 1);
    chk("R4", exp_left, 0);
    check_regs(poke ? "R12" : "R6", s_end, d_end);
    rd_chk("R7", 3'd4, {1'b1, n});
  endtask

  task automatic pulse_chunk(input logic [7:0] exp_len, input bit glitch);
    logic [15:0] s_end;
    logic [12:0] d_end;
    exp_left = 16;
    s_end = exp_src + 16'd16;
    d_end = exp_dst + 13'd16;
    stall_cycles = 0;
    cur_req = "R8";
    @(negedge clk);
    hblank = 1'b1;
    if (glitch) begin
      repeat (4) @(negedge clk);
      hblank = 1'b0;
      repeat (2) @(negedge clk);
      hblank = 1'b1;
    end
    @(negedge clk);
    wait_idle();
    repeat (12) @(negedge clk);
    chk("R8", stall_cycles, 33);
    chk("R8", exp_left, 0);
    hblank = 1'b0;
    check_regs("R6", s_end, d_end);
    rd_chk("R9", 3'd4, exp_len);
  endtask

  initial begin
    logic [15:0] rs, rd;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    // reset state
    rd_chk("R11", 3'd0, 8'h00);
    rd_chk("R11", 3'd3, 8'h00);
    rd_chk("R11", 3'd4, 8'hFF);
    chk("R11", {31'd0, cpu_stall}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", {31'd0, cpu_stall}, 0);

    // directed general runs
    run_general(16'h1237, 16'h8123, 7'd0, 0);
    run_general(16'hFFF5, 16'h9FF9, 7'd1, 0);   // both wrap
    run_general(16'hC000, 16'h0000, 7'h7F, 0);  // longest run
    run_general(16'h4440, 16'h8800, 7'd2, 1);   // writes while stalled
    // random general runs
    for (int k = 0; k < 8; k++) begin
      rs = 16'($urandom);
      rd = 16'($urandom);
      if (rs[15:13] == 3'b100) rs[14] = 1'b1;
      run_general(rs, rd, 7'($urandom_range(0, 9)), 0);
    end

    // blanking-paced mode
    setup_addr(16'h2345, 16'h8F00);
    exp_src = 16'h2340; exp_dst = 13'h0F00;
    exp_left = 0;
    cur_req = "R8";
    wr_reg(3'd4, 8'h82);
    rd_chk("R9", 3'd4, 8'h02);
    repeat (20) @(negedge clk);
    chk("R8", {31'd0, cpu_stall}, 0);
    pulse_chunk(8'h01, 0);
    pulse_chunk(8'h00, 1);
    pulse_chunk(8'hFF, 0);
    cur_req = "R9";
    stall_cycles = 0;
    hblank = 1'b1; repeat (10) @(negedge clk); hblank = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", stall_cycles, 0);
    rd_chk("R9", 3'd4, 8'hFF);

    // cancel
    setup_addr(16'h3000, 16'h8000);
    wr_reg(3'd4, 8'h83);
    rd_chk("R9", 3'd4, 8'h03);
    cur_req = "R10";
    stall_cycles = 0;
    wr_reg(3'd4, 8'h05);
    hblank = 1'b1; repeat (10) @(negedge clk); hblank = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", stall_cycles, 0);
    rd_chk("R10", 3'd4, 8'h85);

    // rejected source in the window
    setup_addr(16'h9A37, 16'h8000);
    cur_req = "R2";
    stall_cycles = 0;
    wr_reg(3'd4, 8'h03);
    repeat (10) @(negedge clk);
    chk("R2", stall_cycles, 0);
    rd_chk("R2", 3'd4, 8'h85);
    wr_reg(3'd4, 8'h81);
    hblank = 1'b1; repeat (10) @(negedge clk); hblank = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2", stall_cycles, 0);
    rd_chk("R2", 3'd4, 8'h85);

    done_flag = 1;
    final_report();
  end
endmodule